// File: doc/BRIEF.md
# Chain-Indexed I/O Translation Buffer

This block is the translation cache of a DMA address-remapping unit. It holds one entry per chain ID, direct mapped. The chain ID is an 8-bit field cut out of the I/O virtual address by a programmable chain mask. The mask sits on the top eight bits of the configured I/O virtual space. Software places the translation data in two staging words, then issues a command. A write command loads the staging words into the entry selected by the command's page address. A purge command invalidates that entry.

A lookup presents a DMA page address. One cycle later the block reports a hit with the stored high and low words, or a miss. Fetching page-directory entries after a miss is the job of the surrounding logic.

The command register holds a page address in bits 31:12 and an opcode in bits 11:0. Opcode 35 means write and opcode 33 means purge. The tag of an entry is the set of address bits above the chain field. Address bits below the chain field, including the 12-bit page offset, play no part in matching.

Top module: `itlb_ctrl`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses. `lk_done_o`, `lk_hit_o` and `lk_miss_o` are 0 until the first lookup.
- R2: A lookup raised on `lk_valid_i` in cycle N is answered in cycle N+1 with `lk_done_o`=1 and exactly one of `lk_hit_o` or `lk_miss_o` set. In any cycle after a cycle with no lookup, all three are 0.
- R3: Writing `reg_sel_i`=0 with opcode 35 in bits 11:0 stores the staging words into the entry whose chain ID is `(wdata & chain_mask) >> pos`. Here pos is the lowest set bit of the mask. The staging high word is written with `reg_sel_i`=1 and the staging low word with `reg_sel_i`=2. A later lookup that matches returns both words on `lk_hi_o` and `lk_lo_o`.
- R4: Bit 0 of an entry's low word is its valid bit. An entry written with this bit at 0 never hits.
- R5: A lookup hits only if the entry is valid and the address bits above the chain field equal those of the command that wrote the entry. Bits below the chain field, the page offset included, are ignored.
- R6: Opcode 33 clears the valid bit of the selected entry only when that entry's tag matches the command's page address. Otherwise the purge has no effect.
- R7: A command with any opcode other than 33 or 35 changes no entry.
- R8: The chain mask is written with `reg_sel_i`=3 and resets to 0x000FF000, so the chain field starts at bit 12. Reprogramming the mask moves both the chain field and the tag boundary for later commands and lookups.
- R9: If a command and a lookup occur in the same cycle, the lookup sees the entry as it was before the command.
- R10: On a miss, `lk_hi_o` and `lk_lo_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 command, 1 staging high, 2 staging low, 3 chain mask |
| reg_wdata_i | input | 32 | Register write data |
| lk_valid_i | input | 1 | Lookup request |
| lk_iova_i | input | 32 | I/O virtual address to translate |
| lk_done_o | output | 1 | Lookup answered this cycle |
| lk_hit_o | output | 1 | Lookup hit |
| lk_miss_o | output | 1 | Lookup missed |
| lk_hi_o | output | 32 | Stored high word on a hit, else 0 |
| lk_lo_o | output | 32 | Stored low word on a hit, else 0 |

## Verification
The assertions assume that the chain mask always holds a contiguous run of eight ones at or above bit 12. This keeps the chain field clear of the page offset. The stimulus programs only 0x000FF000 and 0x00FF0000. The assertions also assume that lookup requests are single-cycle pulses whose address is stable while they are sampled. The bench drives every input on the falling edge and holds it for exactly one cycle. The bench sweeps all 256 chain IDs for reset misses and for write-then-hit. It then exercises the tag, valid-bit, purge, unknown-opcode and same-cycle cases on selected IDs.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
  typedef enum logic [1:0] {
    SEL_CMD    = 2'd0,
    SEL_STG_HI = 2'd1,
    SEL_STG_LO = 2'd2,
    SEL_CMASK  = 2'd3
  } reg_sel_e;

  localparam int unsigned OP_W     = 12;
  localparam int unsigned OP_PURGE = 33;
  localparam int unsigned OP_WRITE = 35;
endpackage

// File: rtl/itlb_cfg.sv
module itlb_cfg import itlb_pkg::*; #(
  parameter int unsigned AW        = 32,
  parameter int unsigned CID_W     = 8,
  parameter int unsigned RST_SHIFT = 12,
  localparam int unsigned SHW      = $clog2(AW)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic [1:0]     reg_sel_i,
  input  logic [AW-1:0]  reg_wdata_i,
  output logic [AW-1:0]  stg_hi_o,
  output logic [AW-1:0]  stg_lo_o,
  output logic [AW-1:0]  cmask_o,
  output logic [SHW-1:0] cshift_o,
  output logic           cmd_wr_o,
  output logic           cmd_purge_o
);
  localparam logic [AW-1:0] CMASK_RST = {{(AW-CID_W){1'b0}}, {CID_W{1'b1}}} << RST_SHIFT;

  function automatic logic [SHW-1:0] low_one(input logic [AW-1:0] m);
    low_one = '0;
    for (int i = AW-1; i >= 0; i--)
      if (m[i]) low_one = i[SHW-1:0];
  endfunction

  reg_sel_e sel;
  logic [OP_W-1:0] op;
  assign sel = reg_sel_e'(reg_sel_i);
  assign op  = reg_wdata_i[OP_W-1:0];

  assign cmd_wr_o    = reg_we_i && sel == SEL_CMD && op == OP_W'(OP_WRITE);
  assign cmd_purge_o = reg_we_i && sel == SEL_CMD && op == OP_W'(OP_PURGE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_hi_o <= '0;
      stg_lo_o <= '0;
      cmask_o  <= CMASK_RST;
      cshift_o <= SHW'(RST_SHIFT);
    end else if (reg_we_i) begin
      case (sel)
        SEL_STG_HI: stg_hi_o <= reg_wdata_i;
        SEL_STG_LO: stg_lo_o <= reg_wdata_i;
        SEL_CMASK: begin
          cmask_o  <= reg_wdata_i;
          cshift_o <= low_one(reg_wdata_i);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/itlb_store.sv
module itlb_store #(
  parameter int unsigned AW    = 32,
  parameter int unsigned CID_W = 8,
  localparam int unsigned N    = 1 << CID_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             purge_i,
  input  logic [CID_W-1:0] cmd_idx_i,
  input  logic [AW-1:0]    cmd_tag_i,
  input  logic [AW-1:0]    whi_i,
  input  logic [AW-1:0]    wlo_i,
  input  logic             rd_i,
  input  logic [CID_W-1:0] rd_idx_i,
  input  logic [AW-1:0]    rd_tag_i,
  output logic             done_o,
  output logic             hit_o,
  output logic [AW-1:0]    hi_o,
  output logic [AW-1:0]    lo_o
);
  logic [N-1:0]  vld_q;
  logic [AW-1:0] hi_q  [N];
  logic [AW-1:0] lo_q  [N];
  logic [AW-1:0] tag_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else if (wr_i) vld_q[cmd_idx_i] <= wlo_i[0];
    else if (purge_i && tag_q[cmd_idx_i] == cmd_tag_i) vld_q[cmd_idx_i] <= 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) begin
      hi_q[cmd_idx_i]  <= whi_i;
      lo_q[cmd_idx_i]  <= wlo_i;
      tag_q[cmd_idx_i] <= cmd_tag_i;
    end
  end

  // read uses pre-write contents: a same-cycle command lands after the lookup
  logic rd_hit;
  assign rd_hit = vld_q[rd_idx_i] && tag_q[rd_idx_i] == rd_tag_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      hit_o  <= 1'b0;
      hi_o   <= '0;
      lo_o   <= '0;
    end else begin
      done_o <= rd_i;
      hit_o  <= rd_i && rd_hit;
      hi_o   <= (rd_i && rd_hit) ? hi_q[rd_idx_i] : '0;
      lo_o   <= (rd_i && rd_hit) ? lo_q[rd_idx_i] : '0;
    end
  end
endmodule

// File: rtl/itlb_ctrl.sv
module itlb_ctrl #(
  parameter int unsigned AW        = 32,
  parameter int unsigned CID_W     = 8,
  parameter int unsigned RST_SHIFT = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [AW-1:0] reg_wdata_i,
  input  logic          lk_valid_i,
  input  logic [AW-1:0] lk_iova_i,
  output logic          lk_done_o,
  output logic          lk_hit_o,
  output logic          lk_miss_o,
  output logic [AW-1:0] lk_hi_o,
  output logic [AW-1:0] lk_lo_o
);
  localparam int unsigned SHW = $clog2(AW);

  logic [AW-1:0]  stg_hi, stg_lo, cmask, tag_mask;
  logic [SHW-1:0] cshift;
  logic           cmd_wr, cmd_purge, hit;

  itlb_cfg #(.AW(AW), .CID_W(CID_W), .RST_SHIFT(RST_SHIFT)) u_cfg (
    .clk_i, .rst_ni, .reg_we_i, .reg_sel_i, .reg_wdata_i,
    .stg_hi_o(stg_hi), .stg_lo_o(stg_lo), .cmask_o(cmask), .cshift_o(cshift),
    .cmd_wr_o(cmd_wr), .cmd_purge_o(cmd_purge)
  );

  // tag = every bit above the chain field
  assign tag_mask = ~(cmask | (cmask - 1'b1));

  logic [CID_W-1:0] cmd_idx, rd_idx;
  assign cmd_idx = CID_W'((reg_wdata_i & cmask) >> cshift);
  assign rd_idx  = CID_W'((lk_iova_i & cmask) >> cshift);

  itlb_store #(.AW(AW), .CID_W(CID_W)) u_store (
    .clk_i, .rst_ni,
    .wr_i(cmd_wr), .purge_i(cmd_purge), .cmd_idx_i(cmd_idx),
    .cmd_tag_i(reg_wdata_i & tag_mask), .whi_i(stg_hi), .wlo_i(stg_lo),
    .rd_i(lk_valid_i), .rd_idx_i(rd_idx), .rd_tag_i(lk_iova_i & tag_mask),
    .done_o(lk_done_o), .hit_o(hit), .hi_o(lk_hi_o), .lo_o(lk_lo_o)
  );

  assign lk_hit_o  = hit;
  assign lk_miss_o = lk_done_o && !hit;
endmodule

// File: rtl/itlb_ctrl_chk.sv
module itlb_ctrl_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          lk_valid_i,
  input logic          lk_done_o,
  input logic          lk_hit_o,
  input logic          lk_miss_o,
  input logic [AW-1:0] lk_hi_o,
  input logic [AW-1:0] lk_lo_o
);
  a_r2_done_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> lk_done_o);
  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> !lk_done_o && !lk_hit_o && !lk_miss_o);
  a_r2_one_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_done_o |-> $onehot({lk_hit_o, lk_miss_o}));
  a_r4_hit_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> lk_lo_o[0]);
  a_r10_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_miss_o |-> lk_hi_o == '0 && lk_lo_o == '0);
endmodule

bind itlb_ctrl itlb_ctrl_chk #(.AW(AW)) u_chk (
  .clk_i, .rst_ni, .lk_valid_i, .lk_done_o, .lk_hit_o, .lk_miss_o, .lk_hi_o, .lk_lo_o
);

// File: tb/sim_itlb_ctrl.sv
`timescale 1ns/1ps
module sim_itlb_ctrl;
  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0, lk_valid = 0;
  logic [1:0]  reg_sel = 0;
  logic [31:0] reg_wdata = 0, lk_iova = 0;
  logic        done, hit, miss;
  logic [31:0] hi, lo;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  itlb_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .lk_valid_i(lk_valid), .lk_iova_i(lk_iova),
    .lk_done_o(done), .lk_hit_o(hit), .lk_miss_o(miss), .lk_hi_o(hi), .lk_lo_o(lo)
  );

  function automatic logic [31:0] exp_hi(int i); return 32'hA500_0000 ^ (i * 32'h0001_0203); endfunction
  function automatic logic [31:0] exp_lo(int i); return 32'h8000_0001 | (i << 8); endfunction

  task automatic chk(string req, logic [98:0] act, logic [98:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic load(logic [31:0] h, logic [31:0] l, logic [31:0] cmd);
    wr(2'd1, h); wr(2'd2, l); wr(2'd0, cmd);
  endtask

  task automatic look(string req, logic [31:0] a, logic eh, logic [31:0] h, logic [31:0] l);
    @(negedge clk); lk_valid = 1; lk_iova = a;
    @(negedge clk); lk_valid = 0;
    chk(req, {done, hit, miss, hi, lo}, {1'b1, eh, !eh, eh ? h : 32'h0, eh ? l : 32'h0});
  endtask

  localparam logic [31:0] TAG = 32'h3AB0_0000;

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle", {96'h0, done, hit, miss}, 99'h0);
    // R1: all chain IDs miss after reset
    for (int i = 0; i < 256; i++) look("R1", TAG | (i << 12), 0, 0, 0);
    @(negedge clk);
    chk("R2 idle after lookup", {96'h0, done, hit, miss}, 99'h0);
    // R3: fill every entry, then sweep with varying offsets
    for (int i = 0; i < 256; i++) load(exp_hi(i), exp_lo(i), TAG | (i << 12) | 35);
    for (int i = 0; i < 256; i++) look("R3", TAG | (i << 12) | ((i * 37) & 12'hFFF), 1, exp_hi(i), exp_lo(i));
    // R5: tag mismatch misses
    for (int i = 0; i < 256; i += 51) look("R5", 32'h3AC0_0000 | (i << 12), 0, 0, 0);
    // R6: non-matching purge is a no-op, matching purge invalidates only that entry
    wr(2'd0, 32'h1110_0000 | (5 << 12) | 33);
    look("R6 nomatch", TAG | (5 << 12), 1, exp_hi(5), exp_lo(5));
    wr(2'd0, TAG | (5 << 12) | 33);
    look("R6 purged", TAG | (5 << 12), 0, 0, 0);
    look("R6 neighbour", TAG | (6 << 12), 1, exp_hi(6), exp_lo(6));
    // R7: unknown opcode leaves entry intact
    load(32'hDEAD_BEEF, 32'h0000_0003, TAG | (7 << 12) | 34);
    look("R7", TAG | (7 << 12), 1, exp_hi(7), exp_lo(7));
    // R4: written with valid bit clear never hits
    load(32'h1234_5678, 32'h0000_0F00, TAG | (9 << 12) | 35);
    look("R4", TAG | (9 << 12), 0, 0, 0);
    // R9: command and lookup in the same cycle
    wr(2'd1, 32'hCAFE_0001); wr(2'd2, 32'h0000_0AA1);
    @(negedge clk);
    reg_we = 1; reg_sel = 0; reg_wdata = TAG | (10 << 12) | 35;
    lk_valid = 1; lk_iova = TAG | (10 << 12);
    @(negedge clk); reg_we = 0; lk_valid = 0;
    chk("R9 old", {done, hit, miss, hi, lo}, {3'b110, exp_hi(10), exp_lo(10)});
    look("R9 new", TAG | (10 << 12), 1, 32'hCAFE_0001, 32'h0000_0AA1);
    // R8: move chain field to bit 16
    wr(2'd3, 32'h00FF_0000);
    load(32'h0BAD_F00D, 32'h0000_0101, 32'h7100_0000 | (8'h42 << 16) | 35);
    look("R8 hit", 32'h7142_3ABC, 1, 32'h0BAD_F00D, 32'h0000_0101);
    look("R8 low bits ignored", 32'h7142_F123, 1, 32'h0BAD_F00D, 32'h0000_0101);
    look("R8 tag miss", 32'h7242_0000, 0, 0, 0);
    look("R10 miss zero", 32'h7143_0000, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule